// File: doc/BRIEF.md
# Display controller init sequencer

This block brings up a page-organised monochrome OLED panel controller. On a start request it drives the panel's reset line through a timed pulse and a settle interval. It then raises the supply enable and emits the controller's configuration as a stream of command bytes. The last byte of the stream switches the display on. On a stop request it sends the display-off command and then drops the supply enable. Each sequence ends with a one-cycle done pulse.

Command bytes leave on a valid/ready byte port that a serial link (not part of this block) consumes. The configuration values arrive on static input pins and must be held stable while a sequence runs. Several option bytes are packed from these fields. One command pair is sent only when one of its options is selected. An optional gamma lookup table of `LUT_LEN` entries can be appended. Any table entry outside the range 31..63 sets a sticky warning.

Top module: `oled_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are cleared after that edge: `panel_rst_o`, `supply_en_o`, `cmd_valid_o`, `done_o` and `lut_warn_o` are 0.
- R2: A `start_i` seen while idle with the supply off holds `panel_rst_o` high for `RST_CYCLES` cycles. It then holds the panel out of reset with the supply off for another `RST_CYCLES` cycles. Only after that does `supply_en_o` rise, and the first command byte is offered in that same cycle. No byte is offered while the supply is off.
- R3: While `cmd_valid_o` is high and `cmd_ready_i` is low, the next cycle keeps `cmd_valid_o` high and `cmd_byte_o` unchanged. A byte counts as sent on a clock edge where both are high.
- R4: The stream opens with these bytes in order: 0x81 then the contrast value; 0xA0 with the segment flip flag in bit 0; 0xC0 with the COM flip flag in bit 3; 0xA8 then rows minus 1; 0xD3 then the row offset.
- R5: The next bytes are 0xD5, then an option byte with (divider minus 1) in bits 3:0 and the oscillator setting in bits 7:4. After the optional area pair of R6 comes 0xD9, then an option byte with precharge phase 1 in bits 3:0 and phase 2 in bits 7:4.
- R6: Between the clock pair and the precharge pair, 0xD8 and an option byte are sent only when area colour or low power is selected. The option byte is the OR of 0x1E (area colour) and 0x05 (low power).
- R7: After the precharge pair come three pairs. The first is 0xDA with an option byte that has bit 1 always set, bit 4 equal to the inverse of the sequential-COM flag, and bit 5 equal to the left/right swap flag. The second is 0xDB then the VCOMH level. The third is 0x8D with an option byte of 0x10, plus 0x04 when the charge pump is needed.
- R8: When the lookup table is enabled, 0x91 and then the `LUT_LEN` entries, entry 0 first, follow the pump pair. When the table is disabled, these bytes are absent.
- R9: `lut_warn_o` rises in the cycle after a table entry below 31 or above 63 is sent. It then stays high until reset.
- R10: The stream ends with 0x20, then 0x02 in page mode or 0x00 in horizontal mode, then 0xAF.
- R11: `done_o` is high for exactly the one cycle after the final byte of a sequence is sent.
- R12: A `stop_i` seen while idle with the supply on offers only 0xAE. In the cycle after that byte is sent, `supply_en_o` is 0 and `done_o` pulses. A `stop_i` with the supply off, or a `start_i` with the supply on, produces no output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request power-up and configuration |
| stop_i | input | 1 | Request display off and supply shutdown |
| contrast_i | input | 8 | Contrast level |
| seg_flip_i | input | 1 | Segment (column) remap flag |
| com_flip_i | input | 1 | COM scan direction flag |
| rows_i | input | 8 | Panel height in rows (1..64) |
| row_offset_i | input | 8 | Vertical display offset |
| clk_div_i | input | 5 | Display clock divider (1..16) |
| osc_freq_i | input | 4 | Oscillator frequency setting |
| area_color_i | input | 1 | Area colour option |
| low_power_i | input | 1 | Low-power option |
| prech1_i | input | 4 | Precharge phase 1 length |
| prech2_i | input | 4 | Precharge phase 2 length |
| com_seq_i | input | 1 | Sequential COM pin layout flag |
| com_lr_swap_i | input | 1 | COM left/right swap flag |
| vcomh_i | input | 8 | VCOMH deselect level |
| pump_need_i | input | 1 | Charge pump required |
| lut_en_i | input | 1 | Send the lookup table |
| lut_i | input | 8*LUT_LEN | Lookup entries, entry i at bits 8i+7:8i |
| page_mode_i | input | 1 | Page addressing (1) or horizontal (0) |
| cmd_ready_i | input | 1 | Consumer accepts the offered byte |
| cmd_valid_o | output | 1 | A command byte is offered |
| cmd_byte_o | output | 8 | Offered command byte |
| panel_rst_o | output | 1 | Panel reset, active high |
| supply_en_o | output | 1 | Panel supply enable |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| lut_warn_o | output | 1 | Sticky out-of-range lookup entry |

## Verification
Some properties are checked by assertions on every cycle. A stalled byte must be held. The reset pin and the supply enable are never both high. No byte is offered without supply, and the first byte is offered when the supply rises. The done flag lasts one cycle, and the supply falls only together with done. The warning is sticky, and the step counter stays within the list. Other behaviour depends on configuration and can only be shown by the bench's scenarios, where a behavioural model is compared on every clock. This covers the exact byte order, the option-byte packing, the skipped area and table steps, the reset and settle lengths, and the ignored start and stop requests.

// File: rtl/oled_init_pkg.sv
// Package: shared phase encoding and command opcodes for the OLED init sequencer.
// Assumes: 8-bit command bytes; opcodes are fixed by the panel controller.
package oled_init_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RST   = 3'd1,
        PH_WAIT  = 3'd2,
        PH_CFG   = 3'd3,
        PH_OFF   = 3'd4
    } seq_phase_t;

    localparam logic [7:0] OP_CONTRAST  = 8'h81;
    localparam logic [7:0] OP_SEG_MAP   = 8'hA0;
    localparam logic [7:0] OP_COM_DIR   = 8'hC0;
    localparam logic [7:0] OP_MUX       = 8'hA8;
    localparam logic [7:0] OP_OFFSET    = 8'hD3;
    localparam logic [7:0] OP_OSC       = 8'hD5;
    localparam logic [7:0] OP_AREA      = 8'hD8;
    localparam logic [7:0] OP_PRECH     = 8'hD9;
    localparam logic [7:0] OP_PINS      = 8'hDA;
    localparam logic [7:0] OP_VCOMH     = 8'hDB;
    localparam logic [7:0] OP_PUMP      = 8'h8D;
    localparam logic [7:0] OP_LUT       = 8'h91;
    localparam logic [7:0] OP_ADDR_MODE = 8'h20;
    localparam logic [7:0] OP_DISP_ON   = 8'hAF;
    localparam logic [7:0] OP_DISP_OFF  = 8'hAE;

    localparam logic [7:0] AREA_COLOR_BITS = 8'h1E;
    localparam logic [7:0] LOW_POWER_BITS  = 8'h05;

    localparam logic [7:0] LUT_MIN = 8'd31;
    localparam logic [7:0] LUT_MAX = 8'd63;

endpackage

// File: rtl/oled_rst_timer.sv
// Module: reset-phase interval timer.
// Counts cycles while run is high and flags the last cycle of each interval
// of CYCLES cycles; the count restarts at once so back-to-back intervals line up.
// Assumes: CYCLES >= 1.
module oled_rst_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == CNT_W'(CYCLES - 1));

    // Advance the interval count, restarting at the end of an interval or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= CNT_W'(CYCLES - 1))); // R2

endmodule

// File: rtl/oled_cmd_list.sv
// Module: configuration byte list.
// Maps a step index onto the command byte for that step, packing option
// fields from the configuration pins, and computes the following step,
// jumping over the area pair and the lookup table when they are not wanted.
// Assumes: LUT_LEN >= 1; configuration pins stable while the list is walked.
module oled_cmd_list
    import oled_init_pkg::*;
#(
    parameter int LUT_LEN = 4,
    parameter int STEP_W  = 5
) (
    input  logic [STEP_W-1:0]    step,
    input  logic [7:0]           contrast_i,
    input  logic                 seg_flip_i,
    input  logic                 com_flip_i,
    input  logic [7:0]           rows_i,
    input  logic [7:0]           row_offset_i,
    input  logic [4:0]           clk_div_i,
    input  logic [3:0]           osc_freq_i,
    input  logic                 area_color_i,
    input  logic                 low_power_i,
    input  logic [3:0]           prech1_i,
    input  logic [3:0]           prech2_i,
    input  logic                 com_seq_i,
    input  logic                 com_lr_swap_i,
    input  logic [7:0]           vcomh_i,
    input  logic                 pump_need_i,
    input  logic                 lut_en_i,
    input  logic [LUT_LEN*8-1:0] lut_i,
    input  logic                 page_mode_i,
    output logic [7:0]           byte_o,
    output logic [STEP_W-1:0]    next_step,
    output logic                 last,
    output logic                 is_lut_entry
);
    localparam int S_OSC_VAL  = 9;
    localparam int S_AREA_CMD = 10;
    localparam int S_PRECH    = 12;
    localparam int S_PUMP_VAL = 19;
    localparam int S_LUT_HDR  = 20;
    localparam int S_LUT0     = 21;
    localparam int S_MODE_CMD = S_LUT0 + LUT_LEN;
    localparam int S_MODE_VAL = S_MODE_CMD + 1;
    localparam int S_ON       = S_MODE_VAL + 1;

    logic [7:0] lut_sel;

    // Pick the lookup entry addressed by the current step.
    always_comb begin
        lut_sel = 8'h00;
        for (int i = 0; i < LUT_LEN; i++) begin
            if (step == STEP_W'(S_LUT0 + i)) begin
                lut_sel = lut_i[i*8 +: 8];
            end
        end
    end

    assign is_lut_entry = (step >= STEP_W'(S_LUT0)) && (step < STEP_W'(S_MODE_CMD));
    assign last         = (step == STEP_W'(S_ON));

    // Produce the byte for the current step.
    always_comb begin
        byte_o = 8'h00;
        if (is_lut_entry) begin
            byte_o = lut_sel;
        end else begin
            case (int'(step))
                0:          byte_o = OP_CONTRAST;
                1:          byte_o = contrast_i;
                2:          byte_o = OP_SEG_MAP | {7'd0, seg_flip_i};
                3:          byte_o = OP_COM_DIR | {4'd0, com_flip_i, 3'd0};
                4:          byte_o = OP_MUX;
                5:          byte_o = rows_i - 8'd1;
                6:          byte_o = OP_OFFSET;
                7:          byte_o = row_offset_i;
                8:          byte_o = OP_OSC;
                S_OSC_VAL:  byte_o = {osc_freq_i, 4'(clk_div_i - 5'd1)};
                S_AREA_CMD: byte_o = OP_AREA;
                11:         byte_o = (area_color_i ? AREA_COLOR_BITS : 8'h00) |
                                     (low_power_i  ? LOW_POWER_BITS  : 8'h00);
                S_PRECH:    byte_o = OP_PRECH;
                13:         byte_o = {prech2_i, prech1_i};
                14:         byte_o = OP_PINS;
                15:         byte_o = {2'b00, com_lr_swap_i, !com_seq_i, 4'b0010};
                16:         byte_o = OP_VCOMH;
                17:         byte_o = vcomh_i;
                18:         byte_o = OP_PUMP;
                S_PUMP_VAL: byte_o = {5'b00010, pump_need_i, 2'b00};
                S_LUT_HDR:  byte_o = OP_LUT;
                S_MODE_CMD: byte_o = OP_ADDR_MODE;
                S_MODE_VAL: byte_o = page_mode_i ? 8'h02 : 8'h00;
                S_ON:       byte_o = OP_DISP_ON;
                default:    byte_o = 8'h00;
            endcase
        end
    end

    // Choose the following step, skipping optional groups.
    always_comb begin
        if (step == STEP_W'(S_OSC_VAL) && !(area_color_i || low_power_i)) begin
            next_step = STEP_W'(S_PRECH);
        end else if (step == STEP_W'(S_PUMP_VAL) && !lut_en_i) begin
            next_step = STEP_W'(S_MODE_CMD);
        end else begin
            next_step = step + 1'b1;
        end
    end

endmodule

// File: rtl/oled_lut_guard.sv
// Module: lookup table range guard.
// Sets a sticky warning when a table entry outside LUT_MIN..LUT_MAX is sent.
// Assumes: accept is high only on the cycle an entry is handed over.
module oled_lut_guard
    import oled_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic [7:0] value,
    output logic       warn
);
    logic bad;

    assign bad = (value < LUT_MIN) || (value > LUT_MAX);

    // Latch the warning until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn <= 1'b0;
        end else if (accept && bad) begin
            warn <= 1'b1;
        end
    end

    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        warn |=> warn); // R9

    AST_WARN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn) |-> $past(accept)); // R9

endmodule

// File: rtl/oled_init_seq.sv
// Module: OLED panel power-up / shutdown command sequencer (top).
// Runs the reset pulse and settle interval, raises the supply, walks the
// configuration byte list over a valid/ready port, and on stop sends the
// display-off byte before dropping the supply. Pulses done at each end.
// Assumes: configuration pins are held stable from start until done.
module oled_init_seq
    import oled_init_pkg::*;
#(
    parameter int RST_CYCLES = 400,
    parameter int LUT_LEN    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic [7:0]           contrast_i,
    input  logic                 seg_flip_i,
    input  logic                 com_flip_i,
    input  logic [7:0]           rows_i,
    input  logic [7:0]           row_offset_i,
    input  logic [4:0]           clk_div_i,
    input  logic [3:0]           osc_freq_i,
    input  logic                 area_color_i,
    input  logic                 low_power_i,
    input  logic [3:0]           prech1_i,
    input  logic [3:0]           prech2_i,
    input  logic                 com_seq_i,
    input  logic                 com_lr_swap_i,
    input  logic [7:0]           vcomh_i,
    input  logic                 pump_need_i,
    input  logic                 lut_en_i,
    input  logic [LUT_LEN*8-1:0] lut_i,
    input  logic                 page_mode_i,
    input  logic                 cmd_ready_i,
    output logic                 cmd_valid_o,
    output logic [7:0]           cmd_byte_o,
    output logic                 panel_rst_o,
    output logic                 supply_en_o,
    output logic                 done_o,
    output logic                 lut_warn_o
);
    localparam int N_STEPS = 24 + LUT_LEN;
    localparam int STEP_W  = $clog2(N_STEPS);

    seq_phase_t        phase;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] next_step;
    logic [7:0]        list_byte;
    logic              list_last;
    logic              list_lut;
    logic              tmr_exp;
    logic              xfer;

    oled_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (phase == PH_RST || phase == PH_WAIT),
        .expired (tmr_exp)
    );

    oled_cmd_list #(.LUT_LEN(LUT_LEN), .STEP_W(STEP_W)) u_list (
        .step          (step),
        .contrast_i    (contrast_i),
        .seg_flip_i    (seg_flip_i),
        .com_flip_i    (com_flip_i),
        .rows_i        (rows_i),
        .row_offset_i  (row_offset_i),
        .clk_div_i     (clk_div_i),
        .osc_freq_i    (osc_freq_i),
        .area_color_i  (area_color_i),
        .low_power_i   (low_power_i),
        .prech1_i      (prech1_i),
        .prech2_i      (prech2_i),
        .com_seq_i     (com_seq_i),
        .com_lr_swap_i (com_lr_swap_i),
        .vcomh_i       (vcomh_i),
        .pump_need_i   (pump_need_i),
        .lut_en_i      (lut_en_i),
        .lut_i         (lut_i),
        .page_mode_i   (page_mode_i),
        .byte_o        (list_byte),
        .next_step     (next_step),
        .last          (list_last),
        .is_lut_entry  (list_lut)
    );

    oled_lut_guard u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (phase == PH_CFG && xfer && list_lut),
        .value  (list_byte),
        .warn   (lut_warn_o)
    );

    assign cmd_valid_o = (phase == PH_CFG) || (phase == PH_OFF);
    assign cmd_byte_o  = (phase == PH_OFF) ? OP_DISP_OFF : list_byte;
    assign panel_rst_o = (phase == PH_RST);
    assign xfer        = cmd_valid_o && cmd_ready_i;

    // Sequence phases, list position, supply enable and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            step        <= '0;
            supply_en_o <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start_i && !supply_en_o) begin
                        phase <= PH_RST;
                    end else if (stop_i && supply_en_o) begin
                        phase <= PH_OFF;
                    end
                end
                PH_RST: begin
                    if (tmr_exp) phase <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (tmr_exp) begin
                        phase       <= PH_CFG;
                        supply_en_o <= 1'b1;
                        step        <= '0;
                    end
                end
                PH_CFG: begin
                    if (xfer) begin
                        if (list_last) begin
                            phase  <= PH_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            step <= next_step;
                        end
                    end
                end
                PH_OFF: begin
                    if (xfer) begin
                        phase       <= PH_IDLE;
                        supply_en_o <= 1'b0;
                        done_o      <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_byte_o))); // R3

    AST_RST_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        panel_rst_o |-> !supply_en_o); // R2

    AST_VALID_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> supply_en_o); // R2

    AST_FIRST_BYTE_AT_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_en_o) |-> cmd_valid_o); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11

    AST_SUPPLY_DROP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en_o) |-> done_o); // R12

    AST_STEP_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CFG) |-> (step < STEP_W'(N_STEPS))); // R10

endmodule

// File: tb/oled_init_seq_tb.sv
// Bench: behavioural model of the sequencer compared against the DUT on every clock.
module oled_init_seq_tb;
    localparam int RST_CYC = 6;
    localparam int LUT_N   = 4;
    localparam int WDOG    = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0;
    logic [7:0] contrast_i = 0, rows_i = 8'd16, row_offset_i = 0, vcomh_i = 0;
    logic seg_flip_i = 0, com_flip_i = 0, area_color_i = 0, low_power_i = 0;
    logic com_seq_i = 0, com_lr_swap_i = 0, pump_need_i = 0, lut_en_i = 0, page_mode_i = 0;
    logic [4:0] clk_div_i = 5'd1;
    logic [3:0] osc_freq_i = 0, prech1_i = 0, prech2_i = 0;
    logic [LUT_N*8-1:0] lut_i = '0;
    logic cmd_ready_i = 1'b1;
    logic cmd_valid_o, panel_rst_o, supply_en_o, done_o, lut_warn_o;
    logic [7:0] cmd_byte_o;

    int checks = 0, fails = 0, cycles = 0;
    int rdy_mode = 0;

    // model state
    int   m_phase = 0;   // 0 idle 1 rst 2 wait 3 cfg 4 off
    int   m_cnt = 0;
    bit   m_sup = 0, m_done = 0, m_warn = 0, armed = 0;
    logic [7:0] q_byte[$];
    string q_tag[$];
    bit   q_lut[$];
    bit   p_valid = 0, p_ready = 0;
    logic [7:0] p_byte = 0;

    oled_init_seq #(.RST_CYCLES(RST_CYC), .LUT_LEN(LUT_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .contrast_i(contrast_i), .seg_flip_i(seg_flip_i), .com_flip_i(com_flip_i),
        .rows_i(rows_i), .row_offset_i(row_offset_i), .clk_div_i(clk_div_i),
        .osc_freq_i(osc_freq_i), .area_color_i(area_color_i), .low_power_i(low_power_i),
        .prech1_i(prech1_i), .prech2_i(prech2_i), .com_seq_i(com_seq_i),
        .com_lr_swap_i(com_lr_swap_i), .vcomh_i(vcomh_i), .pump_need_i(pump_need_i),
        .lut_en_i(lut_en_i), .lut_i(lut_i), .page_mode_i(page_mode_i),
        .cmd_ready_i(cmd_ready_i), .cmd_valid_o(cmd_valid_o), .cmd_byte_o(cmd_byte_o),
        .panel_rst_o(panel_rst_o), .supply_en_o(supply_en_o), .done_o(done_o),
        .lut_warn_o(lut_warn_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic void push(input logic [7:0] b, input string tag, input bit is_lut);
        q_byte.push_back(b); q_tag.push_back(tag); q_lut.push_back(is_lut);
    endfunction

    // Expected configuration stream, written from the requirements.
    function automatic void build_cfg();
        push(8'h81, "R4", 0); push(contrast_i, "R4", 0);
        push(seg_flip_i ? 8'hA1 : 8'hA0, "R4", 0);
        push(com_flip_i ? 8'hC8 : 8'hC0, "R4", 0);
        push(8'hA8, "R4", 0); push(rows_i - 8'd1, "R4", 0);
        push(8'hD3, "R4", 0); push(row_offset_i, "R4", 0);
        push(8'hD5, "R5", 0); push(8'(osc_freq_i) * 16 + 8'(clk_div_i) - 8'd1, "R5", 0);
        if (area_color_i || low_power_i) begin
            push(8'hD8, "R6", 0);
            push((area_color_i ? 8'h1E : 8'h00) | (low_power_i ? 8'h05 : 8'h00), "R6", 0);
        end
        push(8'hD9, "R5", 0); push(8'(prech2_i) * 16 + 8'(prech1_i), "R5", 0);
        push(8'hDA, "R7", 0);
        push(8'h02 + (com_seq_i ? 8'h00 : 8'h10) + (com_lr_swap_i ? 8'h20 : 8'h00), "R7", 0);
        push(8'hDB, "R7", 0); push(vcomh_i, "R7", 0);
        push(8'h8D, "R7", 0); push(pump_need_i ? 8'h14 : 8'h10, "R7", 0);
        if (lut_en_i) begin
            push(8'h91, "R8", 0);
            for (int i = 0; i < LUT_N; i++) push(lut_i[i*8 +: 8], "R8", 1);
        end
        push(8'h20, "R10", 0); push(page_mode_i ? 8'h02 : 8'h00, "R10", 0);
        push(8'hAF, "R10", 0);
    endfunction

    // Per-clock comparison and model advance.
    always @(negedge clk) begin
        cycles++;
        cmd_ready_i = (rdy_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
        if (armed) begin
            chk(panel_rst_o == (m_phase == 1), "R2", panel_rst_o, m_phase == 1);
            chk(supply_en_o == m_sup, "R2/R12", supply_en_o, m_sup);
            chk(cmd_valid_o == (m_phase >= 3), "R2/R12", cmd_valid_o, m_phase >= 3);
            chk(done_o == m_done, "R11", done_o, m_done);
            chk(lut_warn_o == m_warn, "R9", lut_warn_o, m_warn);
            if (p_valid && !p_ready)
                chk(cmd_valid_o && cmd_byte_o == p_byte, "R3", cmd_byte_o, p_byte);
            if (m_phase >= 3 && q_byte.size() > 0)
                chk(cmd_byte_o == q_byte[0], q_tag[0], cmd_byte_o, q_byte[0]);
        end
        p_valid = cmd_valid_o; p_ready = cmd_ready_i; p_byte = cmd_byte_o;
        // state after the next rising edge
        m_done = 0;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_sup = 0; m_warn = 0;
            q_byte.delete(); q_tag.delete(); q_lut.delete();
        end else begin
            case (m_phase)
                0: if (start_i && !m_sup) begin m_phase = 1; m_cnt = 0; build_cfg(); end
                   else if (stop_i && m_sup) begin m_phase = 4; push(8'hAE, "R12", 0); end
                1: if (m_cnt == RST_CYC - 1) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
                2: if (m_cnt == RST_CYC - 1) begin m_phase = 3; m_sup = 1; end else m_cnt++;
                default: if (cmd_ready_i && q_byte.size() > 0) begin
                    if (q_lut[0] && (q_byte[0] < 31 || q_byte[0] > 63)) m_warn = 1;
                    void'(q_byte.pop_front()); void'(q_tag.pop_front()); void'(q_lut.pop_front());
                    if (q_byte.size() == 0) begin
                        if (m_phase == 4) m_sup = 0;
                        m_phase = 0; m_done = 1;
                    end
                end
            endcase
        end
        if (!rst_n) armed = 1;
    end

    always @(posedge clk) begin
        if (cycles > WDOG) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG);
            finish_run();
        end
    end

    task automatic pulse(input bit is_start);
        @(posedge clk); #1;
        if (is_start) start_i = 1; else stop_i = 1;
        @(posedge clk); #1;
        start_i = 0; stop_i = 0;
    endtask

    task automatic wait_idle();
        repeat (3) @(posedge clk);
        while (m_phase != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs cleared under reset
        chk(!panel_rst_o && !supply_en_o && !cmd_valid_o && !done_o && !lut_warn_o,
            "R1", {panel_rst_o, supply_en_o, cmd_valid_o, done_o, lut_warn_o}, 0);
        rst_n = 1;
        // R12: stop with supply off is ignored
        pulse(0); wait_idle();
        chk(!supply_en_o && !cmd_valid_o, "R12", supply_en_o, 0);
        // Config A: minimal options, page mode, pump, ready always high
        contrast_i = 8'h7F; seg_flip_i = 1; rows_i = 8'd32; row_offset_i = 8'd3;
        clk_div_i = 5'd1; osc_freq_i = 4'd8; prech1_i = 4'd2; prech2_i = 4'd15;
        com_seq_i = 0; com_lr_swap_i = 0; vcomh_i = 8'h20; pump_need_i = 1; page_mode_i = 1;
        pulse(1); wait_idle();
        chk(supply_en_o == 1, "R2", supply_en_o, 1);
        // R12: start with supply on is ignored
        pulse(1); wait_idle();
        chk(!cmd_valid_o && !panel_rst_o, "R12", cmd_valid_o, 0);
        pulse(0); wait_idle();
        // Config B: area colour, in-range table, horizontal, stalls on ready
        rdy_mode = 1;
        contrast_i = 8'h10; seg_flip_i = 0; com_flip_i = 1; rows_i = 8'd64; row_offset_i = 0;
        clk_div_i = 5'd16; osc_freq_i = 4'd12; area_color_i = 1; com_seq_i = 1;
        com_lr_swap_i = 1; pump_need_i = 0; lut_en_i = 1; page_mode_i = 0;
        lut_i = {8'd63, 8'd40, 8'd32, 8'd31};
        pulse(1); wait_idle();
        chk(lut_warn_o == 0, "R9", lut_warn_o, 0);
        pulse(0); wait_idle();
        // Config C: low power only, table with an out-of-range entry
        area_color_i = 0; low_power_i = 1; rows_i = 8'd1; clk_div_i = 5'd2;
        lut_i = {8'd40, 8'd64, 8'd50, 8'd30};
        pulse(1); wait_idle();
        chk(lut_warn_o == 1, "R9", lut_warn_o, 1);
        pulse(0); wait_idle();
        // Config D: both area options, in-range table, warning stays set
        area_color_i = 1; lut_i = {8'd33, 8'd34, 8'd35, 8'd36}; page_mode_i = 1;
        pulse(1); wait_idle();
        chk(lut_warn_o == 1, "R9", lut_warn_o, 1);
        pulse(0); wait_idle();
        // R1: reset clears the sticky warning
        rst_n = 0; repeat (2) @(posedge clk); #1;
        chk(lut_warn_o == 0 && supply_en_o == 0, "R1", lut_warn_o, 0);
        rst_n = 1; repeat (3) @(posedge clk);
        finish_run();
    end
endmodule